// File: doc/BRIEF.md
# Chip-Select Wait-State Controller

This block serves one external memory area on a simple processor bus. It holds that area's configuration: a timing byte with separate wait codes for reads and writes, a mode byte with a chip-select enable and a window-mode bit, and a base/mask pair that defines a programmable address window on the upper address bits. The configuration registers are write-only from the bus. When a bus request hits the window and the area is enabled, the block drives chip select and stretches the access to the number of states that the wait code selects. In pin-paced mode it instead keeps the access open for as long as an external wait input stays active. A one-cycle ready pulse marks the final state of every access.

The parameter `SPECIAL_AREA` selects the variant. With the default value of 1, the area comes out of reset enabled and covers the whole 24-bit address space until software switches it to the programmable window. With a value of 0, the area resets disabled and always uses the programmable window.

Top module: `csw_area_ctrl`

## Requirements
- R1: After reset, cs and rdy are low. The write code is 001 and the read code is 101, so the timing byte reads 0x15. In the default special variant the area is enabled with the full-range window, so a read takes 4 states and a write takes 2 states at any address.
- R2: The timing byte holds the write code in bits [6:4] and the read code in bits [2:0]. Fixed codes give these access lengths in states: 001 gives 2, 010 gives 3, 101 gives 4, 110 gives 5, 111 gives 6.
- R3: A read access (req_write=0) is timed by the read code and a write access (req_write=1) by the write code, each independently of the other.
- R4: Code 011 selects pin-paced mode. wait_in is sampled from the second state onward. Each active sample adds one state, and the state with an inactive sample is the last, so an access with k consecutive active samples lasts 2+k states.
- R5: The reserved codes 000 and 100 time the access as 2 states.
- R6: With the enable (mode byte bit 0) at 0, no request asserts cs or rdy.
- R7: With the window-mode bit (mode byte bit 1) at 0, every address matches. With it at 1, a request matches only when (req_addr[23:16] & mask) == (base & mask); the base is written at cfg_sel 2 and the mask at cfg_sel 3. A miss asserts neither cs nor rdy.
- R8: cs stays high for every state of an access. rdy pulses high for exactly one cycle, in the final state, and cs is low in the cycle after.
- R9: A request that arrives while an access is in progress is ignored. A timing write made during an access does not change that access's length; it applies from the next access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 timing, 1 mode, 2 base, 3 mask |
| cfg_data | input | 8 | Configuration write data |
| req | input | 1 | Bus access request, one cycle |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | 24 | Access address |
| wait_in | input | 1 | External wait, active high |
| cs | output | 1 | Chip select, active high |
| rdy | output | 1 | Access completion pulse |

## Verification
A wrong latched timing code or state count shows at the ports as a chip-select pulse of the wrong length. This is visible by the end of the first access after the fault, within at most six cycles for the fixed codes. A wrong window or enable decode shows in the cycle after the request, as a chip select that appears or stays missing. A sequencer that misses its final state leaves cs high past the expected rdy. The bench model flags this on the first extra cycle.

// File: rtl/csw_pkg.sv
package csw_pkg;

    localparam int CODE_W = 3;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 3;
    localparam int SEL_W  = 2;

    localparam logic [CODE_W-1:0] RST_WR_CODE = 3'b001;
    localparam logic [CODE_W-1:0] RST_RD_CODE = 3'b101;
    localparam logic [CODE_W-1:0] PIN_CODE    = 3'b011;

    typedef enum logic [SEL_W-1:0] {
        SEL_TIMING = 2'd0,
        SEL_MODE   = 2'd1,
        SEL_BASE   = 2'd2,
        SEL_MASK   = 2'd3
    } cfg_sel_e;

    typedef enum logic {
        PACE_FIXED = 1'b0,
        PACE_PIN   = 1'b1
    } pace_e;

    typedef struct packed {
        pace_e            pace;
        logic [CNT_W-1:0] states;
    } timing_t;

    // Turns a 3-bit wait code into a pacing mode and a fixed state count.
    function automatic timing_t decode_code(input logic [CODE_W-1:0] code);
        timing_t t;
        t.pace   = PACE_FIXED;
        t.states = CNT_W'(2);
        unique case (code)
            3'b001:   t.states = CNT_W'(2);
            3'b010:   t.states = CNT_W'(3);
            3'b101:   t.states = CNT_W'(4);
            3'b110:   t.states = CNT_W'(5);
            3'b111:   t.states = CNT_W'(6);
            PIN_CODE: t.pace   = PACE_PIN;
            default:  t.states = CNT_W'(2);
        endcase
        return t;
    endfunction

endpackage

// File: rtl/csw_cfg_regs.sv
module csw_cfg_regs
    import csw_pkg::*;
#(
    parameter bit SPECIAL_AREA = 1'b1,
    parameter int MATCH_W      = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [SEL_W-1:0]     wr_sel,
    input  logic [BYTE_W-1:0]    wr_data,
    output logic [CODE_W-1:0]    wr_code,
    output logic [CODE_W-1:0]    rd_code,
    output logic                 area_en,
    output logic                 prog_win,
    output logic [MATCH_W-1:0]   win_base,
    output logic [MATCH_W-1:0]   win_mask
);

    localparam logic RST_EN = SPECIAL_AREA;

    cfg_sel_e sel;
    assign sel = cfg_sel_e'(wr_sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_code  <= RST_WR_CODE;
            rd_code  <= RST_RD_CODE;
            area_en  <= RST_EN;
            prog_win <= 1'b0;
            win_base <= '0;
            win_mask <= '0;
        end else if (wr_en) begin
            unique case (sel)
                SEL_TIMING: begin
                    wr_code <= wr_data[6:4];
                    rd_code <= wr_data[2:0];
                end
                SEL_MODE: begin
                    area_en  <= wr_data[0];
                    prog_win <= wr_data[1];
                end
                SEL_BASE: win_base <= wr_data[MATCH_W-1:0];
                SEL_MASK: win_mask <= wr_data[MATCH_W-1:0];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/csw_win_match.sv
module csw_win_match
    import csw_pkg::*;
#(
    parameter bit SPECIAL_AREA = 1'b1,
    parameter int MATCH_W      = 8
) (
    input  logic [MATCH_W-1:0] addr_hi,
    input  logic               prog_win,
    input  logic [MATCH_W-1:0] win_base,
    input  logic [MATCH_W-1:0] win_mask,
    output logic               hit
);

    logic prog_hit;
    assign prog_hit = ((addr_hi ^ win_base) & win_mask) == '0;

    generate
        if (SPECIAL_AREA) begin : g_special
            assign hit = prog_win ? prog_hit : 1'b1;
        end else begin : g_plain
            logic unused_mode;
            assign unused_mode = prog_win;
            assign hit = prog_hit;
        end
    endgenerate

endmodule

// File: rtl/csw_access_seq.sv
module csw_access_seq
    import csw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              is_write,
    input  logic [CODE_W-1:0] wr_code,
    input  logic [CODE_W-1:0] rd_code,
    input  logic              wait_in,
    output logic              cs,
    output logic              rdy,
    output logic              busy
);

    localparam logic [CNT_W-1:0] CNT_MAX   = '1;
    localparam logic [CNT_W-1:0] PIN_FIRST = CNT_W'(2);

    timing_t          tim_q;
    timing_t          tim_new;
    logic             active_q;
    logic [CNT_W-1:0] cnt_q;
    logic             last;

    assign tim_new = decode_code(is_write ? wr_code : rd_code);

    always_comb begin
        if (tim_q.pace == PACE_FIXED) begin
            last = (cnt_q == tim_q.states);
        end else begin
            last = (cnt_q >= PIN_FIRST) && !wait_in;
        end
    end

    assign cs   = active_q;
    assign busy = active_q;
    assign rdy  = active_q && last;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q     <= 1'b0;
            cnt_q        <= '0;
            tim_q.pace   <= PACE_FIXED;
            tim_q.states <= CNT_W'(2);
        end else if (!active_q) begin
            if (start) begin
                active_q <= 1'b1;
                cnt_q    <= CNT_W'(1);
                tim_q    <= tim_new;
            end
        end else if (last) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
        end else if (cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/csw_area_ctrl.sv
module csw_area_ctrl
    import csw_pkg::*;
#(
    parameter bit SPECIAL_AREA = 1'b1,
    parameter int ADDR_W       = 24,
    parameter int MATCH_W      = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_sel,
    input  logic [7:0]        cfg_data,
    input  logic              req,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              wait_in,
    output logic              cs,
    output logic              rdy
);

    localparam int LOW_W = ADDR_W - MATCH_W;

    logic [CODE_W-1:0]  wr_code;
    logic [CODE_W-1:0]  rd_code;
    logic               area_en;
    logic               prog_win;
    logic [MATCH_W-1:0] win_base;
    logic [MATCH_W-1:0] win_mask;
    logic               addr_hit;
    logic               seq_busy;
    logic               start;
    logic               unused_low;

    assign unused_low = ^req_addr[LOW_W-1:0];

    csw_cfg_regs #(
        .SPECIAL_AREA (SPECIAL_AREA),
        .MATCH_W      (MATCH_W)
    ) regs_i (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (cfg_wr),
        .wr_sel   (cfg_sel),
        .wr_data  (cfg_data),
        .wr_code  (wr_code),
        .rd_code  (rd_code),
        .area_en  (area_en),
        .prog_win (prog_win),
        .win_base (win_base),
        .win_mask (win_mask)
    );

    csw_win_match #(
        .SPECIAL_AREA (SPECIAL_AREA),
        .MATCH_W      (MATCH_W)
    ) match_i (
        .addr_hi  (req_addr[ADDR_W-1 -: MATCH_W]),
        .prog_win (prog_win),
        .win_base (win_base),
        .win_mask (win_mask),
        .hit      (addr_hit)
    );

    assign start = req && !seq_busy && area_en && addr_hit;

    csw_access_seq seq_i (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .is_write (req_write),
        .wr_code  (wr_code),
        .rd_code  (rd_code),
        .wait_in  (wait_in),
        .cs       (cs),
        .rdy      (rdy),
        .busy     (seq_busy)
    );

endmodule

// File: rtl/csw_area_chk.sv
module csw_area_chk (
    input logic clk,
    input logic rst,
    input logic cs,
    input logic rdy,
    input logic en,
    input logic hit
);

    // R8: completion only inside an access
    a_r8_rdy_within_cs: assert property (@(posedge clk) disable iff (rst)
        rdy |-> cs);

    // R8: chip select released after the final state
    a_r8_cs_drops_after_rdy: assert property (@(posedge clk) disable iff (rst)
        rdy |=> !cs);

    // R8: chip select held until completion
    a_r8_cs_held_until_rdy: assert property (@(posedge clk) disable iff (rst)
        (cs && !rdy) |=> cs);

    // R2: every access spans at least two states
    a_r2_no_single_state: assert property (@(posedge clk) disable iff (rst)
        $rose(cs) |-> !rdy);

    // R6: a disabled area never begins an access
    a_r6_disabled_no_start: assert property (@(posedge clk) disable iff (rst)
        (!cs && !en) |=> !cs);

    // R7: a window miss never begins an access
    a_r7_miss_no_start: assert property (@(posedge clk) disable iff (rst)
        (!cs && !hit) |=> !cs);

endmodule

bind csw_area_ctrl csw_area_chk chk_i (
    .clk (clk),
    .rst (rst),
    .cs  (cs),
    .rdy (rdy),
    .en  (area_en),
    .hit (addr_hit)
);

// File: tb/csw_area_ctrl_tb_top.sv
`timescale 1ns/1ps
module csw_area_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [7:0]  cfg_data = 8'd0;
    logic        req = 1'b0;
    logic        req_write = 1'b0;
    logic [23:0] req_addr = 24'd0;
    logic        wait_in = 1'b0;
    logic        cs;
    logic        rdy;

    int    total = 0;
    int    bad = 0;
    int    cycles = 0;
    bit    checking = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    csw_area_ctrl dut_i (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_data(cfg_data), .req(req), .req_write(req_write),
        .req_addr(req_addr), .wait_in(wait_in), .cs(cs), .rdy(rdy)
    );

    // ---------------- reference model ----------------
    int m_wcode = 1, m_rcode = 5;
    bit m_en = 1'b1, m_prog = 1'b0;
    int m_base = 0, m_mask = 0;
    bit m_active = 1'b0;
    int m_n = 0, m_len = 0;

    function automatic int states_of(input int code);
        case (code)
            1: return 2;
            2: return 3;
            5: return 4;
            6: return 5;
            7: return 6;
            3: return 0;
            default: return 2;
        endcase
    endfunction

    function automatic bit m_hit(input logic [23:0] a);
        if (!m_prog) return 1'b1;
        return ((int'(a[23:16]) & m_mask) == (m_base & m_mask));
    endfunction

    function automatic bit m_rdy();
        if (!m_active) return 1'b0;
        if (m_len != 0) return m_n == m_len;
        return (m_n >= 2) && !wait_in;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_wcode = 1; m_rcode = 5; m_en = 1'b1; m_prog = 1'b0;
            m_base = 0; m_mask = 0; m_active = 1'b0; m_n = 0;
        end else begin
            if (m_active) begin
                if (m_rdy()) m_active = 1'b0;
                else m_n++;
            end else if (req && m_en && m_hit(req_addr)) begin
                m_active = 1'b1;
                m_n = 1;
                m_len = states_of(req_write ? m_wcode : m_rcode);
            end
            if (cfg_wr) begin
                case (cfg_sel)
                    2'd0: begin m_wcode = int'(cfg_data[6:4]); m_rcode = int'(cfg_data[2:0]); end
                    2'd1: begin m_en = cfg_data[0]; m_prog = cfg_data[1]; end
                    2'd2: m_base = int'(cfg_data);
                    default: m_mask = int'(cfg_data);
                endcase
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        #2;
        if (checking && !rst && !done) begin
            total++;
            if (cs !== m_active || rdy !== m_rdy()) begin
                bad++;
                $display("FAIL %s cycle %0d: cs=%b rdy=%b expected cs=%b rdy=%b",
                         cur_req, cycles, cs, rdy, m_active, m_rdy());
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic finish_run();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            bad++;
            $display("FAIL watchdog: cycles=%0d expected below 20000", cycles);
            finish_run();
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cfg(input logic [1:0] sel, input logic [7:0] data);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_data = data;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    function automatic logic [7:0] tbyte(input logic [2:0] w, input logic [2:0] r);
        return {1'b0, w, 1'b0, r};
    endfunction

    // One access; k = active wait samples; exp = states expected (0 = no access)
    task automatic access(input string tag, input bit wr, input logic [23:0] a,
                          input int k, input int exp);
        int  n = 0;
        int  pulses = 0;
        bit  got = 1'b0;
        cur_req = tag;
        @(negedge clk);
        req = 1'b1; req_write = wr; req_addr = a;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            req = 1'b0;
            wait_in = (i >= 1) && (i < 1 + k);
            #2;
            if (cs) n++;
            if (rdy) begin pulses++; got = 1'b1; break; end
            if (exp == 0 && i >= 7) break;
        end
        wait_in = 1'b0;
        check({tag, " access length"}, n, exp);
        check({tag, " ready pulses"}, pulses, (exp == 0) ? 0 : 1);
        if (got) begin
            @(negedge clk);
            #2;
            check({tag, " R8 cs low after rdy"}, int'(cs), 0);
        end
    endtask

    // ---------------- stimulus ----------------
    initial begin
        int lens[5] = '{2, 3, 4, 5, 6};
        logic [2:0] codes[5] = '{3'b001, 3'b010, 3'b101, 3'b110, 3'b111};
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        checking = 1'b1;
        #2;
        check("R1 cs after reset", int'(cs), 0);
        check("R1 rdy after reset", int'(rdy), 0);

        access("R1_R3 read default", 1'b0, 24'hABCDEF, 0, 4);
        access("R1_R3 write default", 1'b1, 24'h000010, 0, 2);

        for (int c = 0; c < 5; c++) begin
            cfg(2'd0, tbyte(codes[c], codes[c]));
            access("R2 read code", 1'b0, 24'h123456, 0, lens[c]);
            access("R2 write code", 1'b1, 24'h654321, 0, lens[c]);
        end

        cfg(2'd0, tbyte(3'b111, 3'b010));
        access("R3 read uses read code", 1'b0, 24'h010203, 0, 3);
        access("R3 write uses write code", 1'b1, 24'h010203, 0, 6);

        cfg(2'd0, tbyte(3'b000, 3'b100));
        access("R5 reserved read 100", 1'b0, 24'h0000FF, 0, 2);
        access("R5 reserved write 000", 1'b1, 24'h0000FF, 0, 2);

        cfg(2'd0, tbyte(3'b011, 3'b011));
        access("R4 pin no wait", 1'b0, 24'h200000, 0, 2);
        access("R4 pin three waits", 1'b0, 24'h200000, 3, 5);
        access("R4 pin write one wait", 1'b1, 24'h200000, 1, 3);

        // R9: request and timing write during a running access
        cfg(2'd0, tbyte(3'b001, 3'b111));
        cur_req = "R9";
        @(negedge clk);
        req = 1'b1; req_write = 1'b0; req_addr = 24'h300000;
        n = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            req = (i == 1);
            cfg_wr = (i == 1); cfg_sel = 2'd0; cfg_data = tbyte(3'b001, 3'b001);
            #2;
            if (cs) n++;
        end
        cfg_wr = 1'b0; req = 1'b0;
        check("R9 busy request ignored and length kept", n, 6);
        access("R9 new code applies next", 1'b0, 24'h300000, 0, 2);

        cfg(2'd2, 8'h40);
        cfg(2'd3, 8'hF0);
        cfg(2'd1, 8'h03);
        access("R7 window hit", 1'b0, 24'h4A1234, 0, 2);
        access("R7 window miss", 1'b0, 24'h501234, 0, 0);
        cfg(2'd3, 8'h00);
        access("R7 zero mask hits", 1'b1, 24'hE00000, 0, 2);

        cfg(2'd1, 8'h00);
        access("R6 disabled", 1'b0, 24'h400000, 0, 0);
        access("R6 disabled write", 1'b1, 24'hFFFFFF, 0, 0);
        cfg(2'd1, 8'h01);
        access("R7 full window top", 1'b0, 24'hFFFFFF, 0, 2);

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule